// File: doc/BRIEF.md
# Block I/O Transfer Sequencer

This block moves bytes between a byte-wide I/O port and memory in the manner of the classic eight-bit block input and output string operations. A single start pulse launches a transfer. Three operation bits choose the direction (port to memory, or memory to port), whether the memory pointer HL counts up or down, and whether the transfer runs once or repeats. The block also takes the initial byte counter B, the port low byte C and the 16-bit memory pointer HL.

Each iteration takes two steps. Each step uses exactly one strobe: a port read, a memory write, a memory read or a port write. The port address is the pair {B, C}. Input transfers store the port byte into memory and only then decrement B. Output transfers decrement B before the port write, so the port address of that write already holds the new B. When the transfer ends, the block reports the updated B and HL, a zero flag and a one-cycle done pulse.

A repeating transfer can be held between iterations by a pause request, as an interrupt would hold it. While held, the outputs show the state after the last iteration that finished.

Top module: `blkio_seq`

## Requirements
- R1: A synchronous active-low reset, applied at any time, returns the block to idle. After it, busy, paused, done, zero_flag, every strobe, b_out and hl_out are all 0.
- R2: Input family (op_to_port=0): an iteration first reads the port at address {B,C} with the undecremented B. In the next cycle it writes that byte to memory at HL. B is decremented only after the memory write.
- R3: Output family (op_to_port=1): an iteration first reads memory at HL. B is then decremented. In the next cycle the byte is written to the port at address {B-1,C}.
- R4: After each transfer HL moves by one: up when op_hl_down=0 and down when op_hl_down=1. It wraps modulo 2^16.
- R5: A single transfer (op_repeat=0) performs exactly one iteration, whatever the value of B, including B=0. done is high for exactly one cycle: the cycle after the second clock edge following the edge that samples start.
- R6: A repeating transfer (op_repeat=1) iterates until B reaches 0. It makes B_init iterations, or 256 when B_init=0, and takes two cycles per iteration when it is not paused.
- R7: zero_flag is cleared at start. It is updated at each decrement of B and is 1 exactly when the decremented B is 0. At done it equals (b_out==0).
- R8: If pause is high when a repeating iteration ends and B is not 0, the block holds with paused=1. While held it raises no strobe and keeps b_out, hl_out and zero_flag at their partial values. It resumes the next iteration once pause is low. pause has no effect at the end of a single transfer or of the last iteration.
- R9: A start pulse that arrives while busy=1 is ignored. The running transfer continues with its original operands.
- R10: At most one of mem_rd, mem_we, port_rd and port_we is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch pulse, sampled while idle |
| op_to_port | input | 1 | 1 = memory to port (output family), 0 = port to memory |
| op_hl_down | input | 1 | 1 = HL decrements, 0 = HL increments |
| op_repeat | input | 1 | 1 = repeat until B is 0, 0 = single transfer |
| pause | input | 1 | Hold request applied between iterations |
| b_init | input | 8 | Initial byte counter B |
| c_init | input | 8 | Port low byte C |
| hl_init | input | 16 | Initial memory pointer HL |
| mem_rdata | input | 8 | Memory read data, same cycle as mem_rd |
| port_rdata | input | 8 | Port read data, same cycle as port_rd |
| mem_addr | output | 16 | Memory address (HL) |
| mem_rd | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| port_addr | output | 16 | Port address {B,C} |
| port_rd | output | 1 | Port read strobe |
| port_we | output | 1 | Port write strobe |
| port_wdata | output | 8 | Port write data |
| b_out | output | 8 | Current B |
| hl_out | output | 16 | Current HL |
| zero_flag | output | 1 | B became zero at its last decrement |
| busy | output | 1 | Transfer in progress (including held) |
| paused | output | 1 | Held between iterations |
| done | output | 1 | One-cycle completion pulse |

## Verification
The first strobe appears one cycle after the edge that samples start. The second strobe of an iteration appears one cycle later. b_out, hl_out and zero_flag settle at the iteration's final edge, and done shows in the cycle after the 2N-th edge. The bench drives inputs and samples every output on falling edges. It logs each strobe with its address and data, then compares the log and the count of falling edges before done against a model built from the requirements. For pausing, it checks the held values a full cycle after the hold begins and again several cycles later.

// File: rtl/blkio_pkg.sv
// Shared types for the block I/O transfer sequencer.
// Assumes: one access per state, two states per iteration.
package blkio_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,   // first access of an iteration
        ST_PUT   = 2'd2,   // second access of an iteration
        ST_HOLD  = 2'd3    // parked between iterations
    } seq_state_t;

    typedef struct packed {
        logic to_port;     // 1: memory -> port
        logic hl_down;     // 1: pointer decrements
        logic again;       // 1: repeat until counter is zero
    } xfer_op_t;

endpackage

// File: rtl/blkio_ctrl.sv
// Iteration controller: sequences FETCH/PUT per transfer and decides at
// the end of PUT whether to stop, continue or park in HOLD.
// Assumes: b_after_zero reflects the counter value after this cycle's
// decrement (supplied by the register file).
module blkio_ctrl
    import blkio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       pause,
    input  xfer_op_t   op_in,
    input  logic       b_after_zero,
    output seq_state_t state,
    output xfer_op_t   op_q,
    output logic       load,
    output logic       cap,
    output logic       dec_b,
    output logic       step_hl,
    output logic       done
);

    logic more;

    // Whether another iteration follows the one ending now
    always_comb begin
        more = op_q.again && !b_after_zero;
    end

    // Step enables decoded from the current state
    always_comb begin
        load    = (state == ST_IDLE) && start;
        cap     = (state == ST_FETCH);
        dec_b   = ((state == ST_FETCH) &&  op_q.to_port) ||
                  ((state == ST_PUT)   && !op_q.to_port);
        step_hl = (state == ST_PUT);
    end

    // State register: advance one access per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:  if (start) state <= ST_FETCH;
                ST_FETCH: state <= ST_PUT;
                ST_PUT:   begin
                    if (more) state <= pause ? ST_HOLD : ST_FETCH;
                    else      state <= ST_IDLE;
                end
                ST_HOLD:  if (!pause) state <= ST_FETCH;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Operation latch, captured only when a transfer is accepted
    always_ff @(posedge clk) begin
        if (!rst_n)    op_q <= '0;
        else if (load) op_q <= op_in;
    end

    // Completion pulse, raised for the cycle after the last access
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= (state == ST_PUT) && !more;
    end

endmodule

// File: rtl/blkio_regs.sv
// Register file: counter B, port low byte C, pointer HL, data byte and
// zero flag. Applies the decrement and pointer step on controller enables.
// Assumes: enables are mutually consistent (at most one decrement per
// iteration).
module blkio_regs #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              cap,
    input  logic              dec_b,
    input  logic              step_hl,
    input  logic              to_port,
    input  logic              hl_down,
    input  logic [DATA_W-1:0] b_init,
    input  logic [DATA_W-1:0] c_init,
    input  logic [ADDR_W-1:0] hl_init,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] port_rdata,
    output logic [DATA_W-1:0] b_q,
    output logic [DATA_W-1:0] c_q,
    output logic [ADDR_W-1:0] hl_q,
    output logic [DATA_W-1:0] data_q,
    output logic              zero_q,
    output logic              b_after_zero
);

    localparam logic [DATA_W-1:0] B_ONE  = DATA_W'(1);
    localparam logic [ADDR_W-1:0] HL_ONE = ADDR_W'(1);

    logic [DATA_W-1:0] b_dec;
    logic [DATA_W-1:0] b_after;

    // Counter value after this cycle's optional decrement
    always_comb begin
        b_dec        = b_q - B_ONE;
        b_after      = dec_b ? b_dec : b_q;
        b_after_zero = (b_after == '0);
    end

    // Counter B: loaded at start, decremented on enable
    always_ff @(posedge clk) begin
        if (!rst_n)     b_q <= '0;
        else if (load)  b_q <= b_init;
        else if (dec_b) b_q <= b_dec;
    end

    // Port low byte C: constant for the whole transfer
    always_ff @(posedge clk) begin
        if (!rst_n)    c_q <= '0;
        else if (load) c_q <= c_init;
    end

    // Pointer HL: loaded at start, stepped once per iteration
    always_ff @(posedge clk) begin
        if (!rst_n)       hl_q <= '0;
        else if (load)    hl_q <= hl_init;
        else if (step_hl) hl_q <= hl_down ? hl_q - HL_ONE : hl_q + HL_ONE;
    end

    // Data byte captured from the first access of each iteration
    always_ff @(posedge clk) begin
        if (!rst_n)   data_q <= '0;
        else if (cap) data_q <= to_port ? mem_rdata : port_rdata;
    end

    // Zero flag: cleared at start, follows each decrement
    always_ff @(posedge clk) begin
        if (!rst_n)     zero_q <= 1'b0;
        else if (load)  zero_q <= 1'b0;
        else if (dec_b) zero_q <= (b_dec == '0);
    end

endmodule

// File: rtl/blkio_bus.sv
// Access stage: turns the state and operation into one strobe per cycle
// and forms the memory and port addresses.
// Assumes: read data returns combinationally in the strobe's cycle.
module blkio_bus
    import blkio_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16,
    localparam int PORT_W = 2 * DATA_W
) (
    input  seq_state_t        state,
    input  logic              to_port,
    input  logic [DATA_W-1:0] b_q,
    input  logic [DATA_W-1:0] c_q,
    input  logic [ADDR_W-1:0] hl_q,
    input  logic [DATA_W-1:0] data_q,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [PORT_W-1:0] port_addr,
    output logic              port_rd,
    output logic              port_we,
    output logic [DATA_W-1:0] port_wdata
);

    // Strobe selection: direction picks which side is read first
    always_comb begin
        mem_rd  = (state == ST_FETCH) &&  to_port;
        port_rd = (state == ST_FETCH) && !to_port;
        mem_we  = (state == ST_PUT)   && !to_port;
        port_we = (state == ST_PUT)   &&  to_port;
    end

    // Address and data paths taken straight from the registers
    always_comb begin
        mem_addr   = hl_q;
        port_addr  = {b_q, c_q};
        mem_wdata  = data_q;
        port_wdata = data_q;
    end

endmodule

// File: rtl/blkio_seq.sv
// Top of the block I/O transfer sequencer. Connects the controller, the
// register file and the access stage.
// Assumes: start is a pulse; operands are valid in the cycle it is high.
module blkio_seq
    import blkio_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16,
    localparam int PORT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_to_port,
    input  logic              op_hl_down,
    input  logic              op_repeat,
    input  logic              pause,
    input  logic [DATA_W-1:0] b_init,
    input  logic [DATA_W-1:0] c_init,
    input  logic [ADDR_W-1:0] hl_init,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] port_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [PORT_W-1:0] port_addr,
    output logic              port_rd,
    output logic              port_we,
    output logic [DATA_W-1:0] port_wdata,
    output logic [DATA_W-1:0] b_out,
    output logic [ADDR_W-1:0] hl_out,
    output logic              zero_flag,
    output logic              busy,
    output logic              paused,
    output logic              done
);

    seq_state_t        state;
    xfer_op_t          op_in;
    xfer_op_t          op_q;
    logic              load, cap, dec_b, step_hl, b_after_zero;
    logic [DATA_W-1:0] b_q, c_q, data_q;
    logic [ADDR_W-1:0] hl_q;
    logic              zero_q;

    // Pack the operation inputs
    always_comb begin
        op_in = '{to_port: op_to_port, hl_down: op_hl_down, again: op_repeat};
    end

    blkio_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .pause        (pause),
        .op_in        (op_in),
        .b_after_zero (b_after_zero),
        .state        (state),
        .op_q         (op_q),
        .load         (load),
        .cap          (cap),
        .dec_b        (dec_b),
        .step_hl      (step_hl),
        .done         (done)
    );

    blkio_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (load),
        .cap          (cap),
        .dec_b        (dec_b),
        .step_hl      (step_hl),
        .to_port      (op_q.to_port),
        .hl_down      (op_q.hl_down),
        .b_init       (b_init),
        .c_init       (c_init),
        .hl_init      (hl_init),
        .mem_rdata    (mem_rdata),
        .port_rdata   (port_rdata),
        .b_q          (b_q),
        .c_q          (c_q),
        .hl_q         (hl_q),
        .data_q       (data_q),
        .zero_q       (zero_q),
        .b_after_zero (b_after_zero)
    );

    blkio_bus #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bus (
        .state      (state),
        .to_port    (op_q.to_port),
        .b_q        (b_q),
        .c_q        (c_q),
        .hl_q       (hl_q),
        .data_q     (data_q),
        .mem_addr   (mem_addr),
        .mem_rd     (mem_rd),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .port_addr  (port_addr),
        .port_rd    (port_rd),
        .port_we    (port_we),
        .port_wdata (port_wdata)
    );

    // Status views of the sequencer state
    always_comb begin
        b_out     = b_q;
        hl_out    = hl_q;
        zero_flag = zero_q;
        busy      = (state != ST_IDLE);
        paused    = (state == ST_HOLD);
    end

endmodule

// File: rtl/blkio_seq_chk.sv
// Property checker for blkio_seq, attached through bind.
// Assumes: the top's port names as declared.
module blkio_seq_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16,
    localparam int PORT_W = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pause,
    input logic              mem_rd,
    input logic              mem_we,
    input logic              port_rd,
    input logic              port_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [PORT_W-1:0] port_addr,
    input logic [DATA_W-1:0] b_out,
    input logic [ADDR_W-1:0] hl_out,
    input logic              zero_flag,
    input logic              paused,
    input logic              done
);

    // R10
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_we, port_rd, port_we}));

    // R2
    in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($past(port_rd) && (b_out == $past(b_out)) && (mem_addr == hl_out)));

    // R3
    out_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_we |-> ($past(mem_rd) && (port_addr[PORT_W-1:DATA_W] == $past(b_out) - 8'd1)));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    zero_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (zero_flag == (b_out == '0)));

    // R8
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        paused |-> !(mem_rd || mem_we || port_rd || port_we));

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && pause) |=> ($stable(b_out) && $stable(hl_out) && $stable(zero_flag) && paused));

endmodule

bind blkio_seq blkio_seq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pause     (pause),
    .mem_rd    (mem_rd),
    .mem_we    (mem_we),
    .port_rd   (port_rd),
    .port_we   (port_we),
    .mem_addr  (mem_addr),
    .port_addr (port_addr),
    .b_out     (b_out),
    .hl_out    (hl_out),
    .zero_flag (zero_flag),
    .paused    (paused),
    .done      (done)
);

// File: tb/blkio_seq_bench.sv
`timescale 1ns/1ps
module blkio_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_to_port = 1'b0, op_hl_down = 1'b0, op_repeat = 1'b0;
    logic        pause = 1'b0;
    logic [7:0]  b_init = '0, c_init = '0;
    logic [15:0] hl_init = '0;
    logic [7:0]  mem_rdata, port_rdata;
    logic [15:0] mem_addr, port_addr;
    logic        mem_rd, mem_we, port_rd, port_we;
    logic [7:0]  mem_wdata, port_wdata, b_out;
    logic [15:0] hl_out;
    logic        zero_flag, busy, paused, done;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] mem_model(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction
    function automatic logic [7:0] port_model(input logic [15:0] a);
        return a[7:0] + a[15:8] + 8'h1B;
    endfunction

    assign mem_rdata  = mem_model(mem_addr);
    assign port_rdata = port_model(port_addr);

    blkio_seq u_blkio_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_to_port(op_to_port), .op_hl_down(op_hl_down), .op_repeat(op_repeat),
        .pause(pause), .b_init(b_init), .c_init(c_init), .hl_init(hl_init),
        .mem_rdata(mem_rdata), .port_rdata(port_rdata),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .port_addr(port_addr), .port_rd(port_rd), .port_we(port_we), .port_wdata(port_wdata),
        .b_out(b_out), .hl_out(hl_out), .zero_flag(zero_flag),
        .busy(busy), .paused(paused), .done(done)
    );

    int n_total = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Strobe log (kind 0 port read, 1 mem write, 2 mem read, 3 port write)
    logic [1:0]  lg_k [600];
    logic [15:0] lg_a [600];
    logic [7:0]  lg_d [600];
    int          n_log = 0;
    int          strobe_bad = 0;
    logic        log_clr = 1'b0;

    always @(negedge clk) begin
        if (log_clr) n_log = 0;
        else if (n_log < 600) begin
            if (port_rd) begin lg_k[n_log] = 2'd0; lg_a[n_log] = port_addr; lg_d[n_log] = port_rdata; n_log++; end
            if (mem_we)  begin lg_k[n_log] = 2'd1; lg_a[n_log] = mem_addr;  lg_d[n_log] = mem_wdata;  n_log++; end
            if (mem_rd)  begin lg_k[n_log] = 2'd2; lg_a[n_log] = mem_addr;  lg_d[n_log] = mem_rdata;  n_log++; end
            if (port_we) begin lg_k[n_log] = 2'd3; lg_a[n_log] = port_addr; lg_d[n_log] = port_wdata; n_log++; end
        end
        if ((32'(mem_rd) + 32'(mem_we) + 32'(port_rd) + 32'(port_we)) > 1) strobe_bad++;
    end

    // Watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    // Vector: {to_port, hl_down, repeat, B, C, HL}
    localparam logic [34:0] VECS [10] = '{
        {1'b0, 1'b0, 1'b0, 8'd5, 8'h12, 16'h4000},
        {1'b0, 1'b1, 1'b0, 8'd1, 8'h34, 16'h2000},
        {1'b1, 1'b0, 1'b0, 8'd1, 8'h56, 16'h3000},
        {1'b1, 1'b1, 1'b0, 8'd3, 8'h78, 16'h0000},
        {1'b0, 1'b0, 1'b1, 8'd4, 8'h9A, 16'hFFFE},
        {1'b0, 1'b1, 1'b1, 8'd3, 8'hBC, 16'h0102},
        {1'b1, 1'b0, 1'b1, 8'd7, 8'hDE, 16'h8000},
        {1'b1, 1'b1, 1'b1, 8'd0, 8'hF0, 16'h0050},
        {1'b0, 1'b0, 1'b1, 8'd0, 8'h80, 16'hC000},
        {1'b0, 1'b0, 1'b0, 8'd0, 8'h11, 16'h7000}
    };

    task automatic launch(input logic [34:0] v);
        @(negedge clk) log_clr = 1'b1;
        @(negedge clk) log_clr = 1'b0;
        {op_to_port, op_hl_down, op_repeat, b_init, c_init, hl_init} = v;
        start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    // Count falling edges, starting at the one after the start edge, until done
    task automatic wait_done(output int cycles);
        cycles = 1;
        while (!done && cycles < 2000) begin
            @(negedge clk);
            if (!done) cycles++;
        end
    endtask

    task automatic run_vec(input logic [34:0] v);
        logic [1:0]  ek [600];
        logic [15:0] ea [600];
        logic [7:0]  ed [600];
        logic        out_f = v[34], down_f = v[33], rep_f = v[32];
        logic [7:0]  eb = v[31:24], ec = v[23:16];
        logic [15:0] eh = v[15:0];
        int          iters, ne, cycles, bad;
        iters = rep_f ? ((eb == 0) ? 256 : int'(eb)) : 1;
        ne = 0;
        for (int i = 0; i < iters; i++) begin
            if (!out_f) begin
                ek[ne] = 2'd0; ea[ne] = {eb, ec}; ed[ne] = port_model({eb, ec}); ne++;
                ek[ne] = 2'd1; ea[ne] = eh;       ed[ne] = port_model({eb, ec}); ne++;
                eb = eb - 8'd1;
            end else begin
                ek[ne] = 2'd2; ea[ne] = eh; ed[ne] = mem_model(eh); ne++;
                eb = eb - 8'd1;
                ek[ne] = 2'd3; ea[ne] = {eb, ec}; ed[ne] = mem_model(eh); ne++;
            end
            eh = down_f ? eh - 16'd1 : eh + 16'd1;
        end
        launch(v);
        wait_done(cycles);
        // R5 R6: two cycles per iteration up to done
        chk(cycles == 2 * iters, "R5/R6 cycles to done", cycles, 2 * iters);
        @(negedge clk);
        chk(n_log == ne, "R6 access count", n_log, ne);
        bad = -1;
        for (int i = 0; i < ne && i < n_log; i++)
            if (bad < 0 && (lg_k[i] != ek[i] || lg_a[i] != ea[i] || lg_d[i] != ed[i])) bad = i;
        // R2 R3: order, addresses and data of every access
        if (bad >= 0)
            chk(1'b0, out_f ? "R3 access sequence" : "R2 access sequence",
                {lg_k[bad], 6'd0, lg_d[bad], lg_a[bad]}, {ek[bad], 6'd0, ed[bad], ea[bad]});
        else
            chk(1'b1, "R2/R3 access sequence", 0, 0);
        chk(b_out == eb, "R6 final B", b_out, eb);
        chk(hl_out == eh, "R4 final HL", hl_out, eh);
        chk(zero_flag == (eb == 0), "R7 zero flag", zero_flag, eb == 0);
    endtask

    initial begin
        int cycles;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk({busy, paused, done, zero_flag, mem_rd, mem_we, port_rd, port_we} == 8'd0,
            "R1 reset flags", {busy, paused, done, zero_flag, mem_rd, mem_we, port_rd, port_we}, 0);
        chk(b_out == 0 && hl_out == 0, "R1 reset regs", {b_out, hl_out}, 0);

        foreach (VECS[i]) run_vec(VECS[i]);

        // R8 R9: pause between iterations, start ignored while held
        pause = 1'b1;
        launch({1'b0, 1'b0, 1'b1, 8'd3, 8'h21, 16'h1000});
        @(negedge clk);
        @(negedge clk);
        chk(paused && busy && !done, "R8 held after first iteration", {paused, busy, done}, 3'b110);
        chk(b_out == 8'd2 && hl_out == 16'h1001 && !zero_flag, "R8 partial state",
            {zero_flag, b_out, hl_out}, {1'b0, 8'd2, 16'h1001});
        {op_to_port, op_hl_down, op_repeat, b_init, c_init, hl_init} = {1'b1, 1'b1, 1'b0, 8'd9, 8'h44, 16'h5555};
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (4) @(negedge clk);
        chk(paused && b_out == 8'd2 && hl_out == 16'h1001 && n_log == 2, "R8/R9 still held",
            {paused, b_out, hl_out}, {1'b1, 8'd2, 16'h1001});
        pause = 1'b0;
        wait_done(cycles);
        @(negedge clk);
        chk(b_out == 0 && hl_out == 16'h1003 && zero_flag, "R9 original operands finished",
            {zero_flag, b_out, hl_out}, {1'b1, 8'd0, 16'h1003});
        chk(n_log == 6 && lg_a[2] == 16'h0221 && lg_k[5] == 2'd1, "R9 resumed sequence",
            {n_log[7:0], lg_a[2]}, {8'd6, 16'h0221});

        // R8: pause has no effect on the last iteration or a single transfer
        pause = 1'b1;
        launch({1'b1, 1'b0, 1'b1, 8'd1, 8'h01, 16'h0200});
        wait_done(cycles);
        chk(cycles == 2, "R8 no hold on last iteration", cycles, 2);
        launch({1'b0, 1'b1, 1'b0, 8'd4, 8'h02, 16'h0300});
        wait_done(cycles);
        chk(cycles == 2, "R8 no hold on single transfer", cycles, 2);
        pause = 1'b0;

        // R1: reset in the middle of a repeating transfer
        launch({1'b1, 1'b0, 1'b1, 8'd5, 8'h03, 16'h0400});
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk) rst_n = 1'b1;
        chk(!busy && !done && b_out == 0 && hl_out == 0 &&
            !(mem_rd || mem_we || port_rd || port_we), "R1 mid-transfer reset",
            {busy, b_out, hl_out}, 0);

        // R10: never two strobes in one cycle
        chk(strobe_bad == 0, "R10 single strobe", strobe_bad, 0);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule